// File: doc/BRIEF.md
# Transfer Segment Splitter and Sequencer

This block sits in front of a single-channel transfer engine. It takes one request at a time and turns it into one or two segment commands. A request is either a memory-to-memory copy, given as source, destination and byte length, or a device-side transfer, given as a device address, a memory address, a byte length, a burst word count and a device bus width. Each segment command carries a source address, a destination address, a unit size in bytes, a unit count, and for each side an address-hold flag and a width code. The engine moves `unit × count` bytes for each command.

The unit size the engine accepts is capped at the largest 26-bit value whose low four bits are zero, 0x3FFFFF0 bytes. The unit count is capped at 65535. A copy that fits in one unit is sent as a single command. A longer copy is sent as an aligned bulk command of maximum-size units, then a single-unit command for the remainder. A device transfer uses units of burst words times bus width and must split evenly into them. The block issues each command over a valid/ready port. It waits for the engine's segment-done pulse before it issues the next command. It pulses completion after the last segment. A request the engine cannot express gets a one-cycle reject pulse, and an engine error ends the sequence with an abort pulse.

Top module: `segsplit_top`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `cmd_valid`, `xfer_done`, `req_reject` and `xfer_abort` are 0.
- R2: A copy request (`req_mode` = 0) with a nonzero length no larger than 0x3FFFFF0 produces one command: unit = length, count = 1, the given source and destination, both hold flags 0, both width codes 3 (8 bytes).
- R3: A copy longer than 0x3FFFFF0 first issues unit 0x3FFFFF0 with count = floor(length / 0x3FFFFF0). If bytes remain, it then issues unit = remainder and count = 1, with both addresses advanced by count × 0x3FFFFF0.
- R4: A copy length that is an exact multiple of 0x3FFFFF0 produces only the bulk command, and completion follows its done pulse.
- R5: A copy longer than 0x3FFFFF0 × 65535 is rejected. `req_reject` pulses for one cycle, no command is issued, and the block stays ready. A length equal to that product is accepted with count 65535.
- R6: In device mode the unit is max(burst, 1) × 2^`req_wcode` bytes and the count is length / unit. For device-to-memory (`req_mode` = 1) the source hold flag is 1 with width code `req_wcode`, and the destination increments with width code 3. For memory-to-device (`req_mode` = 2) the roles are swapped.
- R7: A device request is rejected if any of these holds: burst > 65535, length not a multiple of the unit, or count > 65535. `req_mode` = 3 is always rejected.
- R8: A command stays valid with unchanged fields until `cmd_ready`. After the handshake, no further command appears until `seg_done`.
- R9: `xfer_done` pulses for one cycle, in the cycle after the `seg_done` of the final segment.
- R10: `seg_err` while a segment is outstanding pulses `xfer_abort` for one cycle, returns the block to idle, and drops any segments not yet issued.
- R11: A segment of zero bytes is never issued. A zero-length request produces `xfer_done` in the cycle after acceptance, with no command.
- R12: `req_ready` is 0 while a request is in progress, and a `req_valid` in that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_mode | input | 2 | 0 copy, 1 device-to-memory, 2 memory-to-device, 3 reserved |
| req_src | input | ADDR_W | Source address (device address in mode 1) |
| req_dst | input | ADDR_W | Destination address (device address in mode 2) |
| req_len | input | LEN_W | Byte length |
| req_burst | input | BURST_W | Device burst words (0 means 1) |
| req_wcode | input | 2 | Device bus width as log2 of bytes |
| cmd_valid | output | 1 | Segment command valid |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_src | output | ADDR_W | Segment source address |
| cmd_dst | output | ADDR_W | Segment destination address |
| cmd_unit | output | UNIT_W | Unit size in bytes |
| cmd_count | output | CNT_W | Number of units |
| cmd_src_hold | output | 1 | Source address does not increment |
| cmd_dst_hold | output | 1 | Destination address does not increment |
| cmd_src_wcode | output | 2 | Source width code |
| cmd_dst_wcode | output | 2 | Destination width code |
| seg_done | input | 1 | Engine finished the current segment |
| seg_err | input | 1 | Engine error on the current segment |
| xfer_done | output | 1 | Pulse: whole request finished |
| req_reject | output | 1 | Pulse: request rejected |
| xfer_abort | output | 1 | Pulse: request aborted by engine error |

## Verification
Copy lengths are chosen on each side of the split point: a short length gives one command, a length with a remainder gives a bulk command then a remainder command with advanced addresses, and an exact multiple gives no remainder command. The copy limit is tried at the maximum total and at one byte over it, which separates the accept and reject sides. Device requests cover both directions, a zero burst and several widths, so that swapped hold flags and width codes and a missing burst-of-zero fix each show up. Stalled handshakes, a late done pulse, an engine error before the remainder, a zero length and a request sent while busy check the sequencing, the skip rule and the ignore rule.

// File: rtl/segsplit_pkg.sv
package segsplit_pkg;

    // Number of segment slots one request can expand into: bulk then remainder
    localparam int SEG_SLOTS = 2;

    // Width code used on the memory side of every transfer (8 bytes)
    localparam logic [1:0] WC_MEM = 2'd3;

    typedef enum logic [1:0] {
        MODE_COPY    = 2'd0,
        MODE_DEV2MEM = 2'd1,
        MODE_MEM2DEV = 2'd2,
        MODE_RSVD    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/seg_planner.sv
module seg_planner
    import segsplit_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int LEN_W   = 44,
    parameter int UNIT_W  = 26,
    parameter int CNT_W   = 16,
    parameter int BURST_W = 17,
    parameter int ALIGN_W = 4
) (
    input  logic [1:0]                          mode,
    input  logic [ADDR_W-1:0]                   src,
    input  logic [ADDR_W-1:0]                   dst,
    input  logic [LEN_W-1:0]                    len,
    input  logic [BURST_W-1:0]                  burst,
    input  logic [1:0]                          wcode,
    output logic                                reject,
    output logic [SEG_SLOTS-1:0]                seg_vld,
    output logic [SEG_SLOTS-1:0][ADDR_W-1:0]    seg_src,
    output logic [SEG_SLOTS-1:0][ADDR_W-1:0]    seg_dst,
    output logic [SEG_SLOTS-1:0][UNIT_W-1:0]    seg_unit,
    output logic [SEG_SLOTS-1:0][CNT_W-1:0]     seg_cnt,
    output logic                                src_hold,
    output logic                                dst_hold,
    output logic [1:0]                          src_wc,
    output logic [1:0]                          dst_wc
);

    // Largest unit: full unit field with the alignment bits cleared
    localparam logic [63:0] MAX_U64 = ((64'd1 << UNIT_W) - 64'd1) & ~((64'd1 << ALIGN_W) - 64'd1);
    localparam logic [63:0] MAX_C64 = (64'd1 << CNT_W) - 64'd1;
    localparam logic [LEN_W-1:0] MAX_U   = LEN_W'(MAX_U64);
    localparam logic [LEN_W-1:0] MAX_C   = LEN_W'(MAX_C64);
    localparam logic [LEN_W-1:0] MAX_TOT = LEN_W'(MAX_U64 * MAX_C64);

    logic             big;
    logic [LEN_W-1:0] bulk_cnt, bulk_len, rest_len;
    logic [LEN_W-1:0] burst_eff, dev_unit, dev_cnt, dev_mod;

    // Copy split: aligned bulk of maximum units, then the leftover bytes
    assign big      = len >= MAX_U;
    assign bulk_cnt = big ? (len / MAX_U) : LEN_W'(1);
    assign bulk_len = big ? (bulk_cnt * MAX_U) : len;
    assign rest_len = len - bulk_len;

    // Device unit: burst words (zero taken as one) scaled by bus width
    assign burst_eff = (burst == '0) ? LEN_W'(1) : LEN_W'(burst);
    assign dev_unit  = burst_eff << wcode;
    assign dev_cnt   = len / dev_unit;
    assign dev_mod   = len % dev_unit;

    always_comb begin
        reject   = 1'b0;
        seg_vld  = '0;
        seg_src  = '0;
        seg_dst  = '0;
        seg_unit = '0;
        seg_cnt  = '0;
        src_hold = 1'b0;
        dst_hold = 1'b0;
        src_wc   = WC_MEM;
        dst_wc   = WC_MEM;
        case (mode_e'(mode))
            MODE_COPY: begin
                reject      = len > MAX_TOT;
                seg_vld[0]  = len != '0;
                seg_src[0]  = src;
                seg_dst[0]  = dst;
                seg_unit[0] = UNIT_W'(big ? MAX_U : len);
                seg_cnt[0]  = CNT_W'(bulk_cnt);
                seg_vld[1]  = rest_len != '0;
                seg_src[1]  = src + ADDR_W'(bulk_len);
                seg_dst[1]  = dst + ADDR_W'(bulk_len);
                seg_unit[1] = UNIT_W'(rest_len);
                seg_cnt[1]  = CNT_W'(1);
            end
            MODE_DEV2MEM, MODE_MEM2DEV: begin
                reject      = (LEN_W'(burst) > MAX_C) || (dev_mod != '0) || (dev_cnt > MAX_C);
                seg_vld[0]  = len != '0;
                seg_src[0]  = src;
                seg_dst[0]  = dst;
                seg_unit[0] = UNIT_W'(dev_unit);
                seg_cnt[0]  = CNT_W'(dev_cnt);
                if (mode_e'(mode) == MODE_DEV2MEM) begin
                    src_hold = 1'b1;
                    src_wc   = wcode;
                end else begin
                    dst_hold = 1'b1;
                    dst_wc   = wcode;
                end
            end
            default: reject = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import segsplit_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int UNIT_W = 26,
    parameter int CNT_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic                                plan_reject,
    input  logic [SEG_SLOTS-1:0]                plan_vld,
    input  logic [SEG_SLOTS-1:0][ADDR_W-1:0]    plan_src,
    input  logic [SEG_SLOTS-1:0][ADDR_W-1:0]    plan_dst,
    input  logic [SEG_SLOTS-1:0][UNIT_W-1:0]    plan_unit,
    input  logic [SEG_SLOTS-1:0][CNT_W-1:0]     plan_cnt,
    input  logic                                plan_src_hold,
    input  logic                                plan_dst_hold,
    input  logic [1:0]                          plan_src_wc,
    input  logic [1:0]                          plan_dst_wc,
    output logic                                cmd_valid,
    input  logic                                cmd_ready,
    output logic [ADDR_W-1:0]                   cmd_src,
    output logic [ADDR_W-1:0]                   cmd_dst,
    output logic [UNIT_W-1:0]                   cmd_unit,
    output logic [CNT_W-1:0]                    cmd_count,
    output logic                                cmd_src_hold,
    output logic                                cmd_dst_hold,
    output logic [1:0]                          cmd_src_wcode,
    output logic [1:0]                          cmd_dst_wcode,
    input  logic                                seg_done,
    input  logic                                seg_err,
    output logic                                xfer_done,
    output logic                                req_reject,
    output logic                                xfer_abort
);

    localparam int IDX_W = (SEG_SLOTS > 1) ? $clog2(SEG_SLOTS) : 1;

    typedef struct packed {
        seq_state_e                         st;
        logic [IDX_W-1:0]                   idx;
        logic [SEG_SLOTS-1:0]               vld;
        logic [SEG_SLOTS-1:0][ADDR_W-1:0]   src;
        logic [SEG_SLOTS-1:0][ADDR_W-1:0]   dst;
        logic [SEG_SLOTS-1:0][UNIT_W-1:0]   unit;
        logic [SEG_SLOTS-1:0][CNT_W-1:0]    cnt;
        logic                               src_hold;
        logic                               dst_hold;
        logic [1:0]                         src_wc;
        logic [1:0]                         dst_wc;
        logic                               done;
        logic                               rej;
        logic                               abort;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      found;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.rej   = 1'b0;
        seq_d.abort = 1'b0;
        found       = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (plan_reject) begin
                        seq_d.rej = 1'b1;
                    end else begin
                        seq_d.vld      = plan_vld;
                        seq_d.src      = plan_src;
                        seq_d.dst      = plan_dst;
                        seq_d.unit     = plan_unit;
                        seq_d.cnt      = plan_cnt;
                        seq_d.src_hold = plan_src_hold;
                        seq_d.dst_hold = plan_dst_hold;
                        seq_d.src_wc   = plan_src_wc;
                        seq_d.dst_wc   = plan_dst_wc;
                        // Lowest slot holding bytes goes first; empty slots never issue
                        for (int i = SEG_SLOTS - 1; i >= 0; i--) begin
                            if (plan_vld[i]) begin
                                seq_d.idx = IDX_W'(i);
                                found     = 1'b1;
                            end
                        end
                        if (found) seq_d.st   = ST_ISSUE;
                        else       seq_d.done = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) seq_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (seg_err) begin
                    seq_d.abort = 1'b1;
                    seq_d.st    = ST_IDLE;
                end else if (seg_done) begin
                    for (int i = 0; i < SEG_SLOTS; i++) begin
                        if (!found && (i > int'(seq_q.idx)) && seq_q.vld[i]) begin
                            seq_d.idx = IDX_W'(i);
                            found     = 1'b1;
                        end
                    end
                    if (found) begin
                        seq_d.st = ST_ISSUE;
                    end else begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready     = seq_q.st == ST_IDLE;
    assign cmd_valid     = seq_q.st == ST_ISSUE;
    assign cmd_src       = seq_q.src[seq_q.idx];
    assign cmd_dst       = seq_q.dst[seq_q.idx];
    assign cmd_unit      = seq_q.unit[seq_q.idx];
    assign cmd_count     = seq_q.cnt[seq_q.idx];
    assign cmd_src_hold  = seq_q.src_hold;
    assign cmd_dst_hold  = seq_q.dst_hold;
    assign cmd_src_wcode = seq_q.src_wc;
    assign cmd_dst_wcode = seq_q.dst_wc;
    assign xfer_done     = seq_q.done;
    assign req_reject    = seq_q.rej;
    assign xfer_abort    = seq_q.abort;

    // R8: a stalled command holds its contents
    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst)
                                       && $stable(cmd_unit) && $stable(cmd_count)));

    // R11: no empty command ever leaves the block
    p_no_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_unit != '0 && cmd_count != '0));

    // R5: a reject pulse comes with no command and an idle block
    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (!cmd_valid && req_ready));

    // R10: an abort only follows an engine error
    p_abort_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> $past(seg_err));

    // R9: completion follows a segment end or a zero-length request
    p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> ($past(seg_done) || $past(req_valid)));

    // R9, R10: outcome pulses never overlap
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_done, req_reject, xfer_abort}));

endmodule

// File: rtl/segsplit_top.sv
module segsplit_top
    import segsplit_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int LEN_W   = 44,
    parameter int UNIT_W  = 26,
    parameter int CNT_W   = 16,
    parameter int BURST_W = 17,
    parameter int ALIGN_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_mode,
    input  logic [ADDR_W-1:0]   req_src,
    input  logic [ADDR_W-1:0]   req_dst,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [BURST_W-1:0]  req_burst,
    input  logic [1:0]          req_wcode,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [ADDR_W-1:0]   cmd_src,
    output logic [ADDR_W-1:0]   cmd_dst,
    output logic [UNIT_W-1:0]   cmd_unit,
    output logic [CNT_W-1:0]    cmd_count,
    output logic                cmd_src_hold,
    output logic                cmd_dst_hold,
    output logic [1:0]          cmd_src_wcode,
    output logic [1:0]          cmd_dst_wcode,
    input  logic                seg_done,
    input  logic                seg_err,
    output logic                xfer_done,
    output logic                req_reject,
    output logic                xfer_abort
);

    logic                               plan_rej;
    logic [SEG_SLOTS-1:0]               plan_vld;
    logic [SEG_SLOTS-1:0][ADDR_W-1:0]   plan_src, plan_dst;
    logic [SEG_SLOTS-1:0][UNIT_W-1:0]   plan_unit;
    logic [SEG_SLOTS-1:0][CNT_W-1:0]    plan_cnt;
    logic                               plan_src_hold, plan_dst_hold;
    logic [1:0]                         plan_src_wc, plan_dst_wc;

    seg_planner #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .UNIT_W(UNIT_W),
        .CNT_W(CNT_W), .BURST_W(BURST_W), .ALIGN_W(ALIGN_W)
    ) u_planner (
        .mode     (req_mode),
        .src      (req_src),
        .dst      (req_dst),
        .len      (req_len),
        .burst    (req_burst),
        .wcode    (req_wcode),
        .reject   (plan_rej),
        .seg_vld  (plan_vld),
        .seg_src  (plan_src),
        .seg_dst  (plan_dst),
        .seg_unit (plan_unit),
        .seg_cnt  (plan_cnt),
        .src_hold (plan_src_hold),
        .dst_hold (plan_dst_hold),
        .src_wc   (plan_src_wc),
        .dst_wc   (plan_dst_wc)
    );

    seg_sequencer #(
        .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .plan_reject   (plan_rej),
        .plan_vld      (plan_vld),
        .plan_src      (plan_src),
        .plan_dst      (plan_dst),
        .plan_unit     (plan_unit),
        .plan_cnt      (plan_cnt),
        .plan_src_hold (plan_src_hold),
        .plan_dst_hold (plan_dst_hold),
        .plan_src_wc   (plan_src_wc),
        .plan_dst_wc   (plan_dst_wc),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_src       (cmd_src),
        .cmd_dst       (cmd_dst),
        .cmd_unit      (cmd_unit),
        .cmd_count     (cmd_count),
        .cmd_src_hold  (cmd_src_hold),
        .cmd_dst_hold  (cmd_dst_hold),
        .cmd_src_wcode (cmd_src_wcode),
        .cmd_dst_wcode (cmd_dst_wcode),
        .seg_done      (seg_done),
        .seg_err       (seg_err),
        .xfer_done     (xfer_done),
        .req_reject    (req_reject),
        .xfer_abort    (xfer_abort)
    );

    // R3: an accepted copy plan covers exactly the requested bytes
    p_copy_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd0 && !plan_rej) |->
        (({LEN_W{plan_vld[0]}} & (LEN_W'(plan_unit[0]) * LEN_W'(plan_cnt[0])))
         + ({LEN_W{plan_vld[1]}} & (LEN_W'(plan_unit[1]) * LEN_W'(plan_cnt[1]))) == req_len));

    // R6: an accepted device plan moves exactly the requested bytes in one segment
    p_dev_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 2'd0 && !plan_rej && req_len != '0) |->
        ((LEN_W'(plan_unit[0]) * LEN_W'(plan_cnt[0]) == req_len) && !plan_vld[1]));

endmodule

// File: tb/tb_segsplit_top.sv
module tb_segsplit_top;

    localparam int ADDR_W  = 40;
    localparam int LEN_W   = 44;
    localparam int UNIT_W  = 26;
    localparam int CNT_W   = 16;
    localparam int BURST_W = 17;
    localparam logic [63:0] MAXU = 64'h3FFFFF0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, cmd_ready = 1'b0, seg_done = 1'b0, seg_err = 1'b0;
    logic [1:0] req_mode = '0, req_wcode = '0;
    logic [ADDR_W-1:0] req_src = '0, req_dst = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [BURST_W-1:0] req_burst = '0;
    logic req_ready, cmd_valid, cmd_src_hold, cmd_dst_hold, xfer_done, req_reject, xfer_abort;
    logic [ADDR_W-1:0] cmd_src, cmd_dst;
    logic [UNIT_W-1:0] cmd_unit;
    logic [CNT_W-1:0] cmd_count;
    logic [1:0] cmd_src_wcode, cmd_dst_wcode;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    segsplit_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .req_burst(req_burst), .req_wcode(req_wcode), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_unit(cmd_unit),
        .cmd_count(cmd_count), .cmd_src_hold(cmd_src_hold), .cmd_dst_hold(cmd_dst_hold),
        .cmd_src_wcode(cmd_src_wcode), .cmd_dst_wcode(cmd_dst_wcode), .seg_done(seg_done),
        .seg_err(seg_err), .xfer_done(xfer_done), .req_reject(req_reject), .xfer_abort(xfer_abort)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] mode, input logic [63:0] src, input logic [63:0] dst,
                        input logic [63:0] len, input logic [63:0] burst, input logic [1:0] wc);
        @(negedge clk);
        req_mode  = mode;
        req_src   = ADDR_W'(src);
        req_dst   = ADDR_W'(dst);
        req_len   = LEN_W'(len);
        req_burst = BURST_W'(burst);
        req_wcode = wc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic get_cmd(input string tag, input logic [63:0] es, input logic [63:0] ed,
                           input logic [63:0] eu, input logic [63:0] ec,
                           input logic esh, input logic edh, input logic [1:0] esw, input logic [1:0] edw);
        for (int i = 0; i < 10 && !cmd_valid; i++) @(negedge clk);
        chk({tag, " valid"}, 64'(cmd_valid), 64'd1);
        chk({tag, " src"}, 64'(cmd_src), es);
        chk({tag, " dst"}, 64'(cmd_dst), ed);
        chk({tag, " unit"}, 64'(cmd_unit), eu);
        chk({tag, " count"}, 64'(cmd_count), ec);
        chk({tag, " hold"}, {62'd0, cmd_src_hold, cmd_dst_hold}, {62'd0, esh, edh});
        chk({tag, " wcode"}, {60'd0, cmd_src_wcode, cmd_dst_wcode}, {60'd0, esw, edw});
        @(negedge clk);
        chk({tag, " R8 stall hold"}, {cmd_valid, 24'd0, cmd_src}, {1'b1, 24'd0, ADDR_W'(es)});
        chk({tag, " R8 stall unit"}, 64'(cmd_unit), eu);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        chk({tag, " R8 taken"}, 64'(cmd_valid), 64'd0);
    endtask

    task automatic end_seg();
        seg_done = 1'b1;
        @(negedge clk);
        seg_done = 1'b0;
    endtask

    task automatic expect_done(input string tag);
        chk({tag, " R9 done pulse"}, {xfer_done, cmd_valid}, 64'd2);
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, {xfer_done, req_ready}, 64'd1);
    endtask

    task automatic reject_case(input string tag, input logic [1:0] mode, input logic [63:0] len,
                               input logic [63:0] burst, input logic [1:0] wc);
        send(mode, 64'h100, 64'h200, len, burst, wc);
        chk({tag, " reject pulse"}, {req_reject, cmd_valid, req_ready}, 64'b101);
        @(negedge clk);
        chk({tag, " reject over"}, {req_reject, cmd_valid, req_ready, xfer_done}, 64'b0010);
    endtask

    task automatic t_reset();
        chk("R1 reset state", {req_ready, cmd_valid, xfer_done, req_reject, xfer_abort}, 64'b10000);
    endtask

    task automatic t_copy_small();
        send(2'd0, 64'h1000, 64'h2000, 64'd1000, 0, 2'd0);
        get_cmd("R2 small copy", 64'h1000, 64'h2000, 64'd1000, 64'd1, 1'b0, 1'b0, 2'd3, 2'd3);
        repeat (3) @(negedge clk);
        chk("R8 no cmd before seg_done", {cmd_valid, xfer_done}, 64'd0);
        end_seg();
        expect_done("R2");
    endtask

    task automatic t_copy_split();
        logic [63:0] len;
        len = MAXU * 3 + 64'h123;
        send(2'd0, 64'h10_0000_0000, 64'h20_0000_0000, len, 0, 2'd0);
        get_cmd("R3 bulk", 64'h10_0000_0000, 64'h20_0000_0000, MAXU, 64'd3, 1'b0, 1'b0, 2'd3, 2'd3);
        end_seg();
        chk("R9 no done after first of two", 64'(xfer_done), 64'd0);
        get_cmd("R3 remainder", 64'h10_0000_0000 + MAXU * 3, 64'h20_0000_0000 + MAXU * 3,
                64'h123, 64'd1, 1'b0, 1'b0, 2'd3, 2'd3);
        end_seg();
        expect_done("R3");
    endtask

    task automatic t_copy_exact();
        send(2'd0, 64'h40, 64'h80, MAXU * 2, 0, 2'd0);
        get_cmd("R4 exact bulk", 64'h40, 64'h80, MAXU, 64'd2, 1'b0, 1'b0, 2'd3, 2'd3);
        end_seg();
        expect_done("R4 no remainder");
    endtask

    task automatic t_copy_limit();
        send(2'd0, 64'h0, 64'h8000_0000, MAXU * 65535, 0, 2'd0);
        get_cmd("R5 max total", 64'h0, 64'h8000_0000, MAXU, 64'd65535, 1'b0, 1'b0, 2'd3, 2'd3);
        end_seg();
        expect_done("R5 max total");
        reject_case("R5 over limit", 2'd0, MAXU * 65535 + 1, 0, 2'd0);
    endtask

    task automatic t_zero();
        send(2'd0, 64'h500, 64'h600, 64'd0, 0, 2'd0);
        expect_done("R11 zero length");
        repeat (2) @(negedge clk);
        chk("R11 no command", 64'(cmd_valid), 64'd0);
    endtask

    task automatic t_dev();
        send(2'd1, 64'hF0_0000_0000, 64'h8000, 64'd160, 64'd4, 2'd2);
        get_cmd("R6 dev2mem", 64'hF0_0000_0000, 64'h8000, 64'd16, 64'd10, 1'b1, 1'b0, 2'd2, 2'd3);
        end_seg();
        expect_done("R6 dev2mem");
        send(2'd2, 64'h4000, 64'hA000, 64'd7, 64'd0, 2'd0);
        get_cmd("R6 mem2dev burst0", 64'h4000, 64'hA000, 64'd1, 64'd7, 1'b0, 1'b1, 2'd3, 2'd0);
        end_seg();
        expect_done("R6 mem2dev");
    endtask

    task automatic t_reject();
        reject_case("R7 burst too big", 2'd1, 64'd65536 * 2, 64'd65536, 2'd0);
        reject_case("R7 unaligned", 2'd2, 64'd100, 64'd3, 2'd1);
        reject_case("R7 count too big", 2'd1, 64'd65536, 64'd1, 2'd0);
        reject_case("R7 reserved mode", 2'd3, 64'd64, 64'd1, 2'd0);
    endtask

    task automatic t_abort();
        send(2'd0, 64'h1_0000, 64'h2_0000, MAXU * 2 + 64'd5, 0, 2'd0);
        get_cmd("R10 first", 64'h1_0000, 64'h2_0000, MAXU, 64'd2, 1'b0, 1'b0, 2'd3, 2'd3);
        seg_err = 1'b1;
        @(negedge clk);
        seg_err = 1'b0;
        chk("R10 abort pulse", {xfer_abort, xfer_done, req_ready}, 64'b101);
        @(negedge clk);
        chk("R10 abort one cycle", 64'(xfer_abort), 64'd0);
        repeat (3) @(negedge clk);
        chk("R10 remainder dropped", {cmd_valid, req_ready}, 64'b01);
    endtask

    task automatic t_busy();
        send(2'd0, 64'h10, 64'h20, 64'd500, 0, 2'd0);
        get_cmd("R12 first", 64'h10, 64'h20, 64'd500, 64'd1, 1'b0, 1'b0, 2'd3, 2'd3);
        chk("R12 not ready while busy", 64'(req_ready), 64'd0);
        send(2'd3, 64'h0, 64'h0, 64'd0, 0, 2'd0);
        chk("R12 busy request ignored", {req_reject, xfer_done, cmd_valid}, 64'd0);
        end_seg();
        expect_done("R12");
        repeat (3) @(negedge clk);
        chk("R12 no stray command", {cmd_valid, req_reject, xfer_done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy_small();
        t_copy_split();
        t_copy_exact();
        t_copy_limit();
        t_zero();
        t_dev();
        t_reject();
        t_abort();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule